// File: doc/BRIEF.md
# Serial Flash Read Command Responder

This block is the serial-slave front end of a small serial flash model. It watches chip select, serial clock and serial data-in through synchronizers clocked by the system clock. Every transaction starts at a falling chip select. The block then captures an 8-bit opcode, most significant bit first, on rising serial-clock edges. For the two read opcodes it also captures a 24-bit address. It answers three commands. The first is a continuous array read with no dummy clocks. The second is a continuous array read that waits eight don't-care clocks before its data. The third is a status read that repeats the status byte for as long as clocks arrive.

Array data comes from a synthesizable pattern-filled byte array of `2**ARR_AW` entries. Only the low `ARR_AW` address bits are used. With `ARR_AW` = 19 this ignores address bits 23 to 19. The default of 10 keeps the array at 1 KiB. The clock polarity, mode 0 or mode 3, is taken from the serial-clock level seen at each chip select falling edge. The serial output has a data pin and an enable pin. The enable is low whenever nothing is being driven, which stands for high impedance. A busy input from the program engine supplies the ready bit of the status byte.

Top module: `flash_read_responder`

## Requirements
- R1: After reset and whenever chip select is high, `so_en` is 0.
- R2: Opcode 03h is followed by 24 address bits. The first data bit, bit 7 of the byte at the address, appears after the falling edge that follows the 32nd rising edge, and `so_en` is 0 before that. Each byte goes out most significant bit first. The byte at array index a is ((a mod 256)·7 mod 256) XOR (floor(a/256) mod 256) XOR A5h.
- R3: Opcode 0Bh behaves as 03h but inserts 8 don't-care clocks after the address. `so_en` stays 0 through them, and data begins after the falling edge that follows the 40th rising edge.
- R4: Address bits at and above position `ARR_AW` have no effect on which byte is read.
- R5: Each further byte comes from the next index. After index `2**ARR_AW`−1 the next byte comes from index 0, with no extra clocks.
- R6: Opcode 05h sends the status byte starting with bit 7 after the falling edge that follows the 8th rising edge. Bits 7 and 6 are 0, bits 5..2 are 0111, bit 1 is 0 and bit 0 is busy. After bit 0 the byte starts again at bit 7 for as long as clocks arrive.
- R7: The busy bit of each status repetition is the value of `busy_in` when that repetition starts. It is 1 while busy and 0 when ready.
- R8: At each chip select falling edge a low serial-clock level selects mode 0 and a high level selects mode 3. In mode 3 the leading falling edge is not counted. Both modes return identical data. The mode after reset is mode 3.
- R9: A rising chip select ends any command and drops `so_en`. The next command decodes from a fresh start.
- R10: Any opcode other than 03h, 0Bh or 05h makes the block drive nothing until chip select rises.
- R11: The serial output value changes only after a falling serial-clock edge, so it is stable across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| busy_in | input | 1 | Program engine busy flag, reported in status bit 0 |
| so_bit | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for `so_bit`; 0 means high impedance |

## Verification
A wrong bit or phase count inside the block appears at the pins as a whole byte shifted by one or more bit positions. It also appears as `so_en` rising one clock early or late around the 8th, 32nd or 40th edge. Either shows within the first data byte of a transaction. A wrong address pointer corrupts the first byte read or the byte that crosses the top of the array. A stale status byte or a wrong mode decision shows at the next status repetition or at the first data bit after chip select falls.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADR   = 3'd2,
    PH_DUMMY = 3'd3,
    PH_READ  = 3'd4,
    PH_STAT  = 3'd5,
    PH_IGN   = 3'd6
  } phase_t;

  localparam logic [7:0] OPC_RD_SLOW = 8'h03;
  localparam logic [7:0] OPC_RD_FAST = 8'h0B;
  localparam logic [7:0] OPC_STATUS  = 8'h05;

  localparam int CMD_BITS   = 8;
  localparam int ADR_BITS   = 24;
  localparam int DUMMY_BITS = 8;

  // falling-edge index at which the first output bit is presented
  localparam int EDGE_STAT = CMD_BITS;
  localparam int EDGE_SLOW = CMD_BITS + ADR_BITS;
  localparam int EDGE_FAST = CMD_BITS + ADR_BITS + DUMMY_BITS;

  localparam logic [3:0] DENSITY_CODE = 4'b0111;

  function automatic logic [7:0] fill_byte(input logic [23:0] a);
    logic [7:0] lo;
    lo = a[7:0] * 8'd7;
    return lo ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] status_byte(input logic busy);
    return {2'b00, DENSITY_CODE, 1'b0, busy};
  endfunction

endpackage

// File: rtl/frr_pin_sync.sv
module frr_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic cs_act,
  output logic cs_fall,
  output logic sck_lvl,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);

  localparam int NPINS = 3;
  localparam int LAST  = SYNC_STAGES - 1;
  // idle values: deselected, clock high (mode 3 default), data low
  localparam logic [NPINS-1:0] PIN_IDLE = 3'b011;

  logic [NPINS-1:0] pin_in;
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] pin_prev_q;

  assign pin_in = {spi_mosi, spi_sck, spi_csn};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {SYNC_STAGES{PIN_IDLE[p]}};
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in[p]};
    end
    assign pin_s[p] = chain_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= PIN_IDLE;
    else        pin_prev_q <= pin_s;
  end

  assign cs_act   = ~pin_s[0];
  assign cs_fall  = pin_prev_q[0] & ~pin_s[0];
  assign sck_lvl  = pin_s[1];
  assign sck_rise = cs_act & ~pin_prev_q[1] &  pin_s[1];
  assign sck_fall = cs_act &  pin_prev_q[1] & ~pin_s[1];
  assign mosi_s   = pin_s[2];

endmodule

// File: rtl/frr_cmd_decoder.sv
module frr_cmd_decoder
  import flash_rd_pkg::*;
#(
  parameter int ARR_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output phase_t            phase,
  output logic              fast,
  output logic [ARR_AW-1:0] adr_start
);

  localparam int CW = $clog2(ADR_BITS);

  phase_t            phase_q, phase_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [23:0]       sh_q, sh_d, sh_new;
  logic              fast_q, fast_d;
  logic [ARR_AW-1:0] adr_q, adr_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    fast_d  = fast_q;
    adr_d   = adr_q;
    sh_new  = {sh_q[22:0], mosi_s};
    if (!cs_act) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (cs_fall) begin
      phase_d = PH_OPC;
      cnt_d   = '0;
    end else if (sck_rise) begin
      case (phase_q)
        PH_OPC: begin
          sh_d  = sh_new;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(CMD_BITS - 1)) begin
            cnt_d = '0;
            case (sh_new[7:0])
              OPC_RD_SLOW: begin phase_d = PH_ADR; fast_d = 1'b0; end
              OPC_RD_FAST: begin phase_d = PH_ADR; fast_d = 1'b1; end
              OPC_STATUS:  phase_d = PH_STAT;
              default:     phase_d = PH_IGN;
            endcase
          end
        end
        PH_ADR: begin
          sh_d  = sh_new;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(ADR_BITS - 1)) begin
            cnt_d   = '0;
            adr_d   = sh_new[ARR_AW-1:0];
            phase_d = fast_q ? PH_DUMMY : PH_READ;
          end
        end
        PH_DUMMY: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DUMMY_BITS - 1)) begin
            cnt_d   = '0;
            phase_d = PH_READ;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      fast_q  <= 1'b0;
      adr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      fast_q  <= fast_d;
      adr_q   <= adr_d;
    end
  end

  assign phase     = phase_q;
  assign fast      = fast_q;
  assign adr_start = adr_q;

  // R10: an unknown opcode stays ignored while chip select is held low
  a_r10_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGN && cs_act) |=> (phase_q == PH_IGN || !cs_act || phase_q == PH_IDLE));

  // R9: a deselect always returns the decoder to idle
  a_r9_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/frr_pattern_rom.sv
module frr_pattern_rom
  import flash_rd_pkg::*;
#(
  parameter int ARR_AW = 10
) (
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [7:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign cells[i] = fill_byte(24'(i));
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/frr_out_shifter.sv
module frr_out_shifter
  import flash_rd_pkg::*;
#(
  parameter int ARR_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              sck_lvl,
  input  logic              sck_fall,
  input  phase_t            phase,
  input  logic              fast,
  input  logic [ARR_AW-1:0] adr_start,
  input  logic              busy,
  input  logic [7:0]        rd_byte,
  output logic [ARR_AW-1:0] rd_addr,
  output logic              so_bit,
  output logic              so_en
);

  localparam int FW = 6;
  localparam logic [FW-1:0] FMAX = '1;

  logic              mode3_q, mode3_d;
  logic              skip_q, skip_d;
  logic [FW-1:0]     fcnt_q, fcnt_d, fnum, thr;
  logic [2:0]        bitc_q, bitc_d;
  logic [6:0]        sh_q, sh_d;
  logic              so_q, so_d;
  logic              en_q, en_d;
  logic              first_q, first_d;
  logic [ARR_AW-1:0] ptr_q, ptr_d, fetch;
  logic              out_ok;
  logic [7:0]        ld;

  assign fetch   = first_q ? adr_start : ptr_q;
  assign rd_addr = fetch;
  assign fnum    = (fcnt_q == FMAX) ? fcnt_q : fcnt_q + 1'b1;

  always_comb begin
    case (phase)
      PH_STAT: thr = FW'(EDGE_STAT);
      default: thr = fast ? FW'(EDGE_FAST) : FW'(EDGE_SLOW);
    endcase
    out_ok = (phase == PH_READ || phase == PH_STAT) && (fnum >= thr);
    ld     = (phase == PH_STAT) ? status_byte(busy) : rd_byte;
  end

  always_comb begin
    mode3_d = mode3_q;
    skip_d  = skip_q;
    fcnt_d  = fcnt_q;
    bitc_d  = bitc_q;
    sh_d    = sh_q;
    so_d    = so_q;
    en_d    = en_q;
    first_d = first_q;
    ptr_d   = ptr_q;
    if (!cs_act) begin
      en_d   = 1'b0;
      bitc_d = '0;
    end else if (cs_fall) begin
      mode3_d = sck_lvl;
      skip_d  = sck_lvl;
      fcnt_d  = '0;
      bitc_d  = '0;
      first_d = 1'b1;
      en_d    = 1'b0;
    end else if (sck_fall) begin
      if (skip_q) begin
        skip_d = 1'b0;
      end else begin
        fcnt_d = fnum;
        if (out_ok) begin
          en_d   = 1'b1;
          bitc_d = bitc_q + 1'b1;
          if (bitc_q == 3'd0) begin
            so_d = ld[7];
            sh_d = ld[6:0];
            if (phase == PH_READ) begin
              ptr_d   = fetch + 1'b1;
              first_d = 1'b0;
            end
          end else begin
            so_d = sh_q[6];
            sh_d = {sh_q[5:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode3_q <= 1'b1;
      skip_q  <= 1'b0;
      fcnt_q  <= '0;
      bitc_q  <= '0;
      sh_q    <= '0;
      so_q    <= 1'b0;
      en_q    <= 1'b0;
      first_q <= 1'b1;
      ptr_q   <= '0;
    end else begin
      mode3_q <= mode3_d;
      skip_q  <= skip_d;
      fcnt_q  <= fcnt_d;
      bitc_q  <= bitc_d;
      sh_q    <= sh_d;
      so_q    <= so_d;
      en_q    <= en_d;
      first_q <= first_d;
      ptr_q   <= ptr_d;
    end
  end

  assign so_bit = so_q;
  assign so_en  = en_q;

  // R1: deselected means the output is released on the next cycle
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !en_q);

  // R2: output only while the decoder is in a data-returning phase
  a_r2_en_needs_phase: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (phase == PH_READ || phase == PH_STAT));

  // R11: a driven output value moves only after a falling serial clock
  a_r11_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (so_q != $past(so_q))) |-> $past(sck_fall));

  // R8: the mode decision is held between chip select falling edges
  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(mode3_q));

endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
  import flash_rd_pkg::*;
#(
  parameter int ARR_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic busy_in,
  output logic so_bit,
  output logic so_en
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_i;
  logic              cs_act, cs_fall, sck_lvl, sck_rise, sck_fall, mosi_s;
  phase_t            phase;
  logic              fast;
  logic [ARR_AW-1:0] adr_start, rd_addr;
  logic [7:0]        rd_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  frr_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .spi_csn  (spi_csn),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .cs_act   (cs_act),
    .cs_fall  (cs_fall),
    .sck_lvl  (sck_lvl),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  frr_cmd_decoder #(.ARR_AW(ARR_AW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cs_act    (cs_act),
    .cs_fall   (cs_fall),
    .sck_rise  (sck_rise),
    .mosi_s    (mosi_s),
    .phase     (phase),
    .fast      (fast),
    .adr_start (adr_start)
  );

  frr_pattern_rom #(.ARR_AW(ARR_AW)) u_rom (
    .rd_addr (rd_addr),
    .rd_data (rd_byte)
  );

  frr_out_shifter #(.ARR_AW(ARR_AW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cs_act    (cs_act),
    .cs_fall   (cs_fall),
    .sck_lvl   (sck_lvl),
    .sck_fall  (sck_fall),
    .phase     (phase),
    .fast      (fast),
    .adr_start (adr_start),
    .busy      (busy_in),
    .rd_byte   (rd_byte),
    .rd_addr   (rd_addr),
    .so_bit    (so_bit),
    .so_en     (so_en)
  );

endmodule

// File: tb/test_flash_read_responder.sv
module test_flash_read_responder;

  localparam int ARR_AW = 10;
  localparam int DEPTH  = 1 << ARR_AW;
  localparam int HP     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic so_bit, so_en;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit cur_m3 = 1'b1;
  bit first_bit = 1'b0;

  always #5 clk = ~clk;

  flash_read_responder #(.ARR_AW(ARR_AW)) i_flash_read_responder (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck),
    .spi_mosi(mosi), .busy_in(busy), .so_bit(so_bit), .so_en(so_en)
  );

  function automatic logic [7:0] exp_fill(input int a);
    int m;
    m = a % DEPTH;
    return 8'(((m % 256) * 7) % 256) ^ 8'((m / 256) % 256) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] exp_status(input logic b);
    return {2'b00, 4'b0111, 1'b0, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_begin(input bit m3);
    @(negedge clk);
    sck = m3;
    cur_m3 = m3;
    repeat (4) @(negedge clk);
    csn = 1'b0;
    first_bit = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_finish();
    if (!cur_m3) begin sck = 1'b0; repeat (HP) @(negedge clk); end
    csn = 1'b1;
    repeat (6) @(negedge clk);
    chk(so_en == 1'b0, "R9 so_en after deselect", 32'(so_en), 0);
    sck = 1'b1;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                       output bit en_any, output bit en_all, output bit stable_ok);
    en_any = 0; en_all = 1; stable_ok = 1;
    for (int b = 7; b >= 0; b--) begin
      if (!(!cur_m3 && first_bit)) sck = 1'b0;
      first_bit = 1'b0;
      mosi = tx[b];
      repeat (HP) @(negedge clk);
      rx[b] = so_bit;
      if (so_en) en_any = 1; else en_all = 0;
      sck = 1'b1;
      repeat (3) @(negedge clk);
      if (so_en && so_bit !== rx[b]) stable_ok = 0;
      repeat (HP - 3) @(negedge clk);
    end
  endtask

  task automatic do_read(input bit m3, input logic [7:0] opc, input logic [23:0] addr,
                         input int n, input string tag);
    logic [7:0] rx;
    bit ea, eall, st, hdr;
    hdr = 0;
    cs_begin(m3);
    xbyte(opc, rx, ea, eall, st); hdr |= ea;
    xbyte(addr[23:16], rx, ea, eall, st); hdr |= ea;
    xbyte(addr[15:8], rx, ea, eall, st); hdr |= ea;
    xbyte(addr[7:0], rx, ea, eall, st); hdr |= ea;
    if (opc == 8'h0B) begin
      chk(!hdr, "R2 no output during address", 32'(hdr), 0);
      xbyte(8'($urandom), rx, ea, eall, st);
      chk(!ea, "R3 no output during dummy byte", 32'(ea), 0);
    end else begin
      chk(!hdr, "R2 no output during opcode/address", 32'(hdr), 0);
    end
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = exp_fill(int'(addr) + k);
      xbyte(8'($urandom), rx, ea, eall, st);
      chk(rx == e, tag, 32'(rx), 32'(e));
      chk(eall, "R2 so_en during data", 32'(eall), 1);
      chk(st, "R11 output stable across rising edge", 32'(st), 1);
    end
    cs_finish();
  endtask

  task automatic do_stat(input bit m3, input int n, input int flip_at);
    logic [7:0] rx;
    bit ea, eall, st;
    cs_begin(m3);
    xbyte(8'h05, rx, ea, eall, st);
    chk(!ea, "R6 no output during opcode", 32'(ea), 0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      if (k == flip_at) busy = ~busy;
      e = exp_status(busy);
      xbyte(8'($urandom), rx, ea, eall, st);
      chk(rx == e && eall, (k == flip_at) ? "R7 live busy bit" : "R6 status repeat", 32'(rx), 32'(e));
      chk(st, "R11 status stable across rising edge", 32'(st), 1);
    end
    cs_finish();
  endtask

  task automatic do_unknown(input bit m3, input logic [7:0] opc);
    logic [7:0] rx;
    bit ea, eall, st, any;
    any = 0;
    cs_begin(m3);
    xbyte(opc, rx, ea, eall, st); any |= ea;
    for (int k = 0; k < 4; k++) begin
      xbyte(8'($urandom), rx, ea, eall, st); any |= ea;
    end
    chk(!any, "R10 unknown opcode stays silent", 32'(any), 0);
    cs_finish();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(so_en == 1'b0, "R1 released after reset", 32'(so_en), 0);

    // R2 / R8: same read in both modes
    do_read(1'b0, 8'h03, 24'h000123, 4, "R2 slow read mode 0");
    do_read(1'b1, 8'h03, 24'h000123, 4, "R8 slow read mode 3");
    // R3: fast read with dummy byte
    do_read(1'b1, 8'h0B, 24'h0002F0, 3, "R3 fast read mode 3");
    // R4: upper address bits ignored
    do_read(1'b0, 8'h0B, 24'hFFFC05, 3, "R4 upper address ignored");
    do_read(1'b1, 8'h03, 24'h7A8001, 2, "R4 upper address ignored mode 3");
    // R5: wrap at the top of the array
    do_read(1'b0, 8'h03, 24'(DEPTH - 2), 5, "R5 wrap to index 0");
    do_read(1'b1, 8'h0B, 24'(DEPTH - 1), 3, "R5 wrap fast read");
    // R6 / R7: status repeat and live busy
    busy = 1'b0;
    do_stat(1'b0, 3, -1);
    do_stat(1'b1, 4, 2);
    do_stat(1'b0, 3, 1);
    busy = 1'b0;
    // R10: unknown opcodes
    do_unknown(1'b0, 8'h9F);
    do_unknown(1'b1, 8'hFF);
    // R9: command after an ignored one decodes freshly
    do_read(1'b0, 8'h03, 24'h000000, 2, "R9 fresh decode after ignore");

    for (int it = 0; it < 20; it++) begin
      bit m3;
      int kind;
      logic [23:0] a;
      int n;
      m3   = 1'($urandom % 2);
      kind = int'($urandom % 4);
      a    = 24'($urandom);
      n    = 1 + int'($urandom % 4);
      case (kind)
        0: do_read(m3, 8'h03, a, n, "R2 random slow read");
        1: do_read(m3, 8'h0B, a, n, "R3 random fast read");
        2: begin busy = 1'($urandom % 2); do_stat(m3, n, int'($urandom % 4)); end
        default: do_unknown(m3, 8'h40 | 8'($urandom % 64));
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule